// File: doc/BRIEF.md
# Channel Transfer Address and Count Sequencer

This block is the per-channel engine of a legacy-style DMA channel. Software-visible setup logic outside the block holds a page value, a base address and a base count. The block loads those values into its own current address and current count. On each acknowledged transfer strobe it produces one physical bus address and the matching byte enables. It then advances the current address by one and retires one count. The bus handshake and the register interface are handled by neighbouring logic.

The page is concatenated with the 16-bit current address, never added to it. The address therefore wraps inside its own 64K window and cannot carry into the page. A channel can run in byte mode, where one address step is one byte. It can also run in word mode, where one address step is one 16-bit word. In word mode the whole mapping moves up by one bit, page bit 0 is dropped and physical bit 0 is held at zero.

The count register holds the number of transfers minus one, so a transfer block always has at least one transfer. Terminal count marks the transfer on which the count underflows. After that transfer the channel either reloads itself from the base values, in auto-initialise mode, or masks itself. The residue output gives the remaining work at any time.

Top module: `dma_xfer_seq`

## Requirements
- R1: After synchronous reset the channel is masked (`mask_o`=1), `be_o`=0, `tc_o`=0, `phys_addr_o`=0 and the internal count is 0, so `residue_o` reads 1.
- R2: A `load_i` cycle copies `base_addr_i` and `base_cnt_i` into the current address and current count, and clears the mask.
- R3: In byte mode (`word_mode_i`=0), a transfer drives `phys_addr_o[23:16]` from `page_i[7:0]` and `phys_addr_o[15:0]` from the current address. The outputs are registered and appear one clock after the strobe.
- R4: In word mode (`word_mode_i`=1), a transfer drives `phys_addr_o[23:17]` from `page_i[7:1]`, `phys_addr_o[16:1]` from the current address and `phys_addr_o[0]`=0. `page_i[0]` has no effect.
- R5: After each accepted transfer the current address increments modulo 65536. The page part of `phys_addr_o` never changes because of this wrap.
- R6: Each accepted transfer decrements the current count by one. `tc_o` is 1 on the output cycle of the transfer that was taken with a count of 0x0000, and 0 on every other cycle.
- R7: In byte mode `residue_o` equals (current count + 1) mod 65536.
- R8: In word mode `residue_o` equals twice (current count + 1) mod 65536, expressed as a byte count.
- R9: With `autoinit_i`=1 at the terminal transfer, the current address and count reload from `base_addr_i` and `base_cnt_i`, and the channel stays unmasked.
- R10: With `autoinit_i`=0 at the terminal transfer, the channel sets its mask. While the mask is set, `xfer_i` produces no transfer: `be_o` stays 0 and the address and count do not change.
- R11: A word transfer drives `be_o`=2'b11. A byte transfer drives `be_o`=2'b01 when the physical address bit 0 is 0 and 2'b10 when it is 1. `be_o`=0 on every cycle without a transfer.
- R12: When `load_i` and `xfer_i` are both high in the same cycle, the load wins and no transfer is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Copy base values into the current registers and unmask the channel |
| xfer_i | input | 1 | Acknowledged transfer strobe |
| word_mode_i | input | 1 | 1 selects 16-bit word channel mapping |
| autoinit_i | input | 1 | Reload from the base values after terminal count |
| page_i | input | 8 | Page value |
| base_addr_i | input | 16 | Base address |
| base_cnt_i | input | 16 | Base count, transfers minus one |
| phys_addr_o | output | 24 | Registered physical address of the last transfer |
| be_o | output | 2 | Registered byte enables, zero when there is no transfer |
| tc_o | output | 1 | Registered terminal count pulse |
| mask_o | output | 1 | Channel masked |
| residue_o | output | 17 | Remaining transfer amount in bytes |

## Verification
A wrong current address shows up on `phys_addr_o` on the very next transfer. The clearest cases are a carry leaking into the page bits after 0xFFFF, and a page bit 0 that survives in word mode. A wrong current count shows up at once on `residue_o`, in the clock right after the faulty update. It also shifts the `tc_o` pulse by at least one transfer. A mask or reload fault appears on the first strobe after terminal count: a stray `be_o`, or an address that did not return to the base value.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    BE_NONE = 2'b00,
    BE_LOW  = 2'b01,
    BE_HIGH = 2'b10,
    BE_BOTH = 2'b11
  } byte_en_e;
endpackage

// File: rtl/dma_addr_map.sv
module dma_addr_map
  import dma_seq_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16,
  localparam int PHYS_W = PAGE_W + ADDR_W
) (
  input  logic              word_mode,
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [PHYS_W-1:0] phys,
  output logic [1:0]        be
);
  logic [PHYS_W-1:0] phys_byte;
  logic [PHYS_W-1:0] phys_word;

  // byte: page sits directly above the address, no adder anywhere
  assign phys_byte = {page, cur_addr};
  // word: mapping moves up one bit, lowest page bit dropped
  assign phys_word = {page[PAGE_W-1:1], cur_addr, 1'b0};

  always_comb begin
    if (word_mode) begin
      phys = phys_word;
      be   = BE_BOTH;
    end else begin
      phys = phys_byte;
      be   = phys_byte[0] ? BE_HIGH : BE_LOW;
    end
  end
endmodule

// File: rtl/dma_cur_regs.sv
module dma_cur_regs #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              autoinit,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] base_cnt,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] cur_cnt,
  output logic              masked,
  output logic              at_end
);
  assign at_end = (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      masked   <= 1'b1;
    end else if (load) begin
      cur_addr <= base_addr;
      cur_cnt  <= base_cnt;
      masked   <= 1'b0;
    end else if (step) begin
      if (at_end && autoinit) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else begin
        cur_addr <= cur_addr + 1'b1;
        cur_cnt  <= cur_cnt - 1'b1;
        if (at_end) masked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_residue.sv
module dma_residue #(
  parameter int ADDR_W = 16,
  localparam int RES_W = ADDR_W + 1
) (
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] cur_cnt,
  output logic [RES_W-1:0]  residue
);
  logic [ADDR_W-1:0] left;
  assign left    = cur_cnt + 1'b1;
  assign residue = word_mode ? {left, 1'b0} : {1'b0, left};
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16,
  localparam int PHYS_W = PAGE_W + ADDR_W,
  localparam int RES_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              xfer_i,
  input  logic              word_mode_i,
  input  logic              autoinit_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W-1:0] base_cnt_i,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic [1:0]        be_o,
  output logic              tc_o,
  output logic              mask_o,
  output logic [RES_W-1:0]  residue_o
);
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] cur_cnt;
  logic              masked;
  logic              at_end;
  logic              step;
  logic [PHYS_W-1:0] phys_nxt;
  logic [1:0]        be_nxt;

  // load has priority; masked channel ignores strobes
  assign step = xfer_i && !load_i && !masked;

  dma_cur_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .load(load_i), .step(step), .autoinit(autoinit_i),
    .base_addr(base_addr_i), .base_cnt(base_cnt_i),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .masked(masked), .at_end(at_end)
  );

  dma_addr_map #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) map_i (
    .word_mode(word_mode_i), .page(page_i), .cur_addr(cur_addr),
    .phys(phys_nxt), .be(be_nxt)
  );

  dma_residue #(.ADDR_W(ADDR_W)) res_i (
    .word_mode(word_mode_i), .cur_cnt(cur_cnt), .residue(residue_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr_o <= '0;
      be_o        <= '0;
      tc_o        <= 1'b0;
    end else begin
      be_o <= step ? be_nxt : 2'b00;
      tc_o <= step && at_end;
      if (step) phys_addr_o <= phys_nxt;
    end
  end

  assign mask_o = masked;
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int PHYS_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              autoinit_i,
  input logic [PHYS_W-1:0] phys_addr_o,
  input logic [1:0]        be_o,
  input logic              tc_o,
  input logic              mask_o
);
  // R4 word transfers never land on an odd byte
  assert_word_even_R4: assert property (@(posedge clk) disable iff (rst)
    (be_o == 2'b11) |-> (phys_addr_o[0] == 1'b0));

  // R10 a masked channel issues nothing on the next cycle
  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    mask_o |=> (be_o == 2'b00));

  // R6 terminal count only marks a real transfer
  assert_tc_on_xfer_R6: assert property (@(posedge clk) disable iff (rst)
    tc_o |-> (be_o != 2'b00));

  // R10 without reload, terminal count leaves the channel masked
  assert_tc_masks_R10: assert property (@(posedge clk) disable iff (rst)
    (tc_o && !$past(autoinit_i)) |-> mask_o);

  // R9 with reload, terminal count keeps the channel live
  assert_tc_reload_live_R9: assert property (@(posedge clk) disable iff (rst)
    (tc_o && $past(autoinit_i)) |-> !mask_o);

  // R5 back-to-back byte transfers step the low address by one, mod 64K
  assert_byte_step_R5: assert property (@(posedge clk) disable iff (rst)
    ((be_o == 2'b01 || be_o == 2'b10) &&
     ($past(be_o) == 2'b01 || $past(be_o) == 2'b10) && !$past(tc_o))
    |-> (phys_addr_o[15:0] == $past(phys_addr_o[15:0]) + 16'd1));
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.PHYS_W(PHYS_W)) chk_i (
  .clk(clk), .rst(rst), .autoinit_i(autoinit_i), .phys_addr_o(phys_addr_o),
  .be_o(be_o), .tc_o(tc_o), .mask_o(mask_o)
);

// File: tb/dma_xfer_seq_tb_top.sv
module dma_xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        load_i, xfer_i, word_mode_i, autoinit_i;
  logic [7:0]  page_i;
  logic [15:0] base_addr_i, base_cnt_i;
  logic [23:0] phys_addr_o;
  logic [1:0]  be_o;
  logic        tc_o, mask_o;
  logic [16:0] residue_o;

  int n_run = 0;
  int n_fail = 0;
  string req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  dma_xfer_seq dut_i (
    .clk(clk), .rst(rst), .load_i(load_i), .xfer_i(xfer_i),
    .word_mode_i(word_mode_i), .autoinit_i(autoinit_i), .page_i(page_i),
    .base_addr_i(base_addr_i), .base_cnt_i(base_cnt_i),
    .phys_addr_o(phys_addr_o), .be_o(be_o), .tc_o(tc_o), .mask_o(mask_o),
    .residue_o(residue_o)
  );

  // behavioural reference
  int m_addr, m_cnt, m_mask, m_phys, m_be, m_tc;
  always @(posedge clk) begin
    if (rst) begin
      m_addr = 0; m_cnt = 0; m_mask = 1; m_phys = 0; m_be = 0; m_tc = 0;
    end else if (load_i) begin
      m_addr = base_addr_i; m_cnt = base_cnt_i; m_mask = 0; m_be = 0; m_tc = 0;
    end else if (xfer_i && m_mask == 0) begin
      if (word_mode_i) begin
        m_phys = ((page_i / 2) * 131072) + m_addr * 2;
        m_be = 3;
      end else begin
        m_phys = page_i * 65536 + m_addr;
        m_be = (m_addr % 2 == 1) ? 2 : 1;
      end
      m_tc = (m_cnt == 0);
      if (m_cnt == 0 && autoinit_i) begin
        m_addr = base_addr_i; m_cnt = base_cnt_i;
      end else begin
        m_addr = (m_addr + 1) % 65536;
        if (m_cnt == 0) begin m_mask = 1; m_cnt = 65535; end
        else m_cnt = m_cnt - 1;
      end
    end else begin
      m_be = 0; m_tc = 0;
    end
  end

  function automatic int exp_res();
    int r = (m_cnt + 1) % 65536;
    return word_mode_i ? r * 2 : r;
  endfunction

  always @(negedge clk) begin
    if (!done && $time > 12) begin
      n_run++;
      if (phys_addr_o !== m_phys[23:0] || be_o !== m_be[1:0] || tc_o !== m_tc[0] ||
          mask_o !== m_mask[0] || residue_o !== exp_res()) begin
        n_fail++;
        $display("FAIL %s: got addr=%h be=%b tc=%b mask=%b res=%0d exp addr=%h be=%b tc=%0d mask=%0d res=%0d",
                 req, phys_addr_o, be_o, tc_o, mask_o, residue_o,
                 m_phys[23:0], m_be[1:0], m_tc, m_mask, exp_res());
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [15:0] a, input logic [15:0] c);
    base_addr_i = a; base_cnt_i = c; load_i = 1; tick(); load_i = 0;
  endtask

  task automatic strobes(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      xfer_i = 1; tick(); xfer_i = 0;
      if (gap) tick();
    end
  endtask

  initial begin
    rst = 1; load_i = 0; xfer_i = 0; word_mode_i = 0; autoinit_i = 0;
    page_i = 8'h00; base_addr_i = 0; base_cnt_i = 0;
    tick(2); rst = 0;
    req = "R1"; tick(2);
    req = "R10"; strobes(2, 0);                 // masked after reset
    req = "R12"; base_addr_i = 16'h3401; base_cnt_i = 16'd3;
    load_i = 1; xfer_i = 1; tick(); load_i = 0; xfer_i = 0; tick();
    req = "R2"; tick();
    req = "R3"; page_i = 8'h12; strobes(2, 1);
    req = "R11"; strobes(1, 0);
    req = "R6"; strobes(1, 0); tick();
    req = "R10"; strobes(3, 0);
    req = "R5"; page_i = 8'hA7; do_load(16'hFFFE, 16'd4); strobes(5, 0); tick();
    req = "R7"; do_load(16'h0000, 16'hFFFF); tick(); do_load(16'h0010, 16'd0); tick();
    req = "R4"; word_mode_i = 1; page_i = 8'h35; do_load(16'hFFFF, 16'd1);
    strobes(1, 1); page_i = 8'h34; strobes(1, 0); tick();
    req = "R8"; do_load(16'h0100, 16'd9); strobes(3, 1); tick();
    req = "R9"; word_mode_i = 0; autoinit_i = 1; page_i = 8'h02;
    do_load(16'h0041, 16'd1); strobes(5, 0); tick(); strobes(2, 1);
    autoinit_i = 0; strobes(4, 0);
    req = "R1"; rst = 1; tick(); rst = 0; tick(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule